// File: doc/BRIEF.md
# Audio controller interrupt aggregator

This block gathers every interrupt source of a multi-stream audio controller into a single interrupt status word and one level-sensitive interrupt request line. Each stream brings three event flags (completion, FIFO error, descriptor error) and three matching enables. The response ring brings two event flags and two enables. The codec link brings one state-change flag per codec and a wake mask. A global control word holds the global enable, the controller enable and one interrupt enable per stream.

The status word is combinational and follows its inputs in the same cycle. Bit i is stream i. Bit N is the controller summary, where N is the stream count. Bit N+1 is the global summary. The global summary is informational and never drives the line. The line is registered: it changes one clock edge after the computed level changes. In the cycle the line changes, a one-cycle pulse marks a rise or a fall.

Top module: `audio_irq_agg`

## Requirements
- R1: Stream i's status bit (bit i) is set, in the same cycle, when that stream's flags ANDed with its enables are nonzero. Flag/enable bit 0 is completion, bit 1 is FIFO error and bit 2 is descriptor error. A flag whose enable is clear does not set the bit.
- R2: The controller bit (bit N) is set when the ring flags ANDed with the ring enables are nonzero, or when any codec state-change flag is set, whatever the wake mask holds. Ring bit 0 is response and ring bit 1 is overrun.
- R3: The controller bit is also set when the codec state-change flags ANDed with the wake mask are nonzero.
- R4: The global bit (bit N+1) is set exactly when any stream bit or the controller bit is set.
- R5: One edge after the inputs settle, the line equals the global enable ANDed with the OR of two terms: controller enable AND controller bit, and any stream bit whose stream interrupt enable is set.
- R6: When the global bit is set but the controller enable and all stream enables are clear, or when the global enable is clear, the line stays low.
- R7: The line keeps its registered level until the computed level differs. The rise pulse is high for exactly the one cycle in which the line has just gone from 0 to 1. The fall pulse is high for exactly the one cycle in which it has just gone from 1 to 0. The two pulses are never high together.
- R8: During reset the line and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strm_flags | input | NSTRM x 3 | Per-stream event flags {desc err, FIFO err, completion} |
| strm_en | input | NSTRM x 3 | Per-stream enables for those flags |
| ring_flags | input | 2 | Response ring flags {overrun, response} |
| ring_en | input | 2 | Response ring enables |
| codec_chg | input | NCODEC | Codec state-change flags |
| wake_en | input | NCODEC | Codec wake mask |
| glb_en | input | 1 | Global interrupt enable |
| ctrl_en | input | 1 | Controller interrupt enable |
| strm_ie | input | NSTRM | Per-stream interrupt enables |
| int_status | output | NSTRM+2 | Status word {global, controller, streams} |
| irq | output | 1 | Registered interrupt line |
| irq_rise | output | 1 | One-cycle pulse on a line assertion |
| irq_fall | output | 1 | One-cycle pulse on a line deassertion |

## Verification
The clocked assertions assume that the inputs change only between clock edges and hold steady across each rising edge. The bench meets this by driving every input just after a falling edge. It samples the combinational status word shortly after driving the inputs, and it samples the registered line and pulses on the next falling edge. The assertions treat each input as a plain level, with no protocol behind it. The bench therefore sets flags and enables in arbitrary combinations, including flags whose enables are clear and a global bit that has no line enable behind it.

// File: rtl/audio_irq_agg.sv
module audio_irq_agg #(
  parameter int NSTRM  = 8,
  parameter int NCODEC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSTRM-1:0][2:0] strm_flags,
  input  logic [NSTRM-1:0][2:0] strm_en,
  input  logic [1:0]            ring_flags,
  input  logic [1:0]            ring_en,
  input  logic [NCODEC-1:0]     codec_chg,
  input  logic [NCODEC-1:0]     wake_en,
  input  logic                  glb_en,
  input  logic                  ctrl_en,
  input  logic [NSTRM-1:0]      strm_ie,
  output logic [NSTRM+1:0]      int_status,
  output logic                  irq,
  output logic                  irq_rise,
  output logic                  irq_fall
);
  localparam int CBIT = NSTRM;
  localparam int GBIT = NSTRM + 1;

  logic [NSTRM-1:0] sbits;
  logic             cbit;
  logic             want;

  for (genvar i = 0; i < NSTRM; i++) begin : g_strm
    assign sbits[i] = |(strm_flags[i] & strm_en[i]);
  end

  assign cbit = (|(ring_flags & ring_en)) | (|codec_chg) | (|(codec_chg & wake_en));
  assign int_status = {(|sbits) | cbit, cbit, sbits};
  assign want = glb_en & ((ctrl_en & cbit) | (|(strm_ie & sbits)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      irq_rise <= 1'b0;
      irq_fall <= 1'b0;
    end else begin
      irq_rise <= want & ~irq;
      irq_fall <= ~want & irq;
      if (want != irq) irq <= want;
    end
  end

  // R4
  gis_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((strm_flags[0] & strm_en[0]) != 3'b000) |-> int_status[GBIT]);

  // R2
  ring_cis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ring_flags & ring_en) != 2'b00) |-> int_status[CBIT]);

  // R6
  no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en || (!ctrl_en && strm_ie == '0)) |=> !irq);

  // R7
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |-> (irq && !$past(irq)));

  // R7
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fall |-> (!irq && $past(irq)));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_rise, irq_fall}));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_rise && !irq_fall) |-> $stable(irq));
endmodule

// File: tb/audio_irq_agg_test.sv
module audio_irq_agg_test;
  localparam int NSTRM  = 8;
  localparam int NCODEC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSTRM-1:0][2:0] strm_flags = '0;
  logic [NSTRM-1:0][2:0] strm_en = '0;
  logic [1:0] ring_flags = '0, ring_en = '0;
  logic [NCODEC-1:0] codec_chg = '0, wake_en = '0;
  logic glb_en = 1'b0, ctrl_en = 1'b0;
  logic [NSTRM-1:0] strm_ie = '0;
  logic [NSTRM+1:0] int_status;
  logic irq, irq_rise, irq_fall;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_irq_agg #(.NSTRM(NSTRM), .NCODEC(NCODEC)) uut (
    .clk(clk), .rst_n(rst_n), .strm_flags(strm_flags), .strm_en(strm_en),
    .ring_flags(ring_flags), .ring_en(ring_en), .codec_chg(codec_chg),
    .wake_en(wake_en), .glb_en(glb_en), .ctrl_en(ctrl_en), .strm_ie(strm_ie),
    .int_status(int_status), .irq(irq), .irq_rise(irq_rise), .irq_fall(irq_fall));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    strm_flags = '0; strm_en = '0; ring_flags = '0; ring_en = '0;
    codec_chg = '0; wake_en = '0; glb_en = 0; ctrl_en = 0; strm_ie = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 irq", irq, 0);
    chk("R8 pulses", {irq_rise, irq_fall}, 0);
    chk("R8 status", int_status, 0);
  endtask

  task automatic t_stream();
    for (int b = 0; b < 3; b++) begin
      @(negedge clk); clear_all();
      strm_flags[3][b] = 1; strm_en[3][b] = 1; #1;
      chk("R1 stream3 flag", int_status, 10'h208);
    end
    @(negedge clk); clear_all();
    strm_flags[5] = 3'b010; strm_en[5] = 3'b101; #1;
    chk("R1 masked flag", int_status, 10'h000);
    strm_flags[0] = 3'b100; strm_en[0] = 3'b100; strm_flags[7] = 3'b001; strm_en[7] = 3'b001; #1;
    chk("R1 streams 0 and 7", int_status, 10'h281);
    chk("R4 global", int_status[9], 1);
  endtask

  task automatic t_ctrl();
    @(negedge clk); clear_all();
    ring_flags = 2'b01; ring_en = 2'b01; #1;
    chk("R2 ring response", int_status, 10'h300);
    ring_flags = 2'b10; ring_en = 2'b10; #1;
    chk("R2 ring overrun", int_status, 10'h300);
    ring_flags = 2'b10; ring_en = 2'b01; #1;
    chk("R2 ring masked", int_status, 10'h000);
    ring_flags = 0; codec_chg = 4'b0100; wake_en = 0; #1;
    chk("R2 codec change unmasked", int_status, 10'h300);
    codec_chg = 4'b0010; wake_en = 4'b0010; #1;
    chk("R3 codec and wake", int_status, 10'h300);
  endtask

  task automatic t_line();
    @(negedge clk); clear_all();
    glb_en = 1; strm_ie[3] = 1; strm_flags[3] = 3'b001; strm_en[3] = 3'b001;
    @(negedge clk);
    chk("R5 line up", irq, 1);
    chk("R7 rise pulse", {irq_rise, irq_fall}, 2'b10);
    @(negedge clk);
    chk("R7 rise one cycle", {irq, irq_rise, irq_fall}, 3'b100);
    strm_flags[3] = 0;
    @(negedge clk);
    chk("R5 line down", irq, 0);
    chk("R7 fall pulse", {irq_rise, irq_fall}, 2'b01);
    @(negedge clk);
    chk("R7 fall one cycle", {irq, irq_rise, irq_fall}, 3'b000);
    ctrl_en = 1; codec_chg = 4'b1000;
    @(negedge clk);
    chk("R5 controller line", {irq, irq_rise}, 2'b11);
    strm_flags[3] = 3'b001; strm_en[3] = 3'b001;
    @(negedge clk);
    chk("R7 no pulse while held", {irq, irq_rise, irq_fall}, 3'b100);
    codec_chg = 0; strm_flags[3] = 0;
    @(negedge clk);
    chk("R5 line clears", {irq, irq_fall}, 2'b01);
  endtask

  task automatic t_gis_only();
    @(negedge clk); clear_all();
    glb_en = 1; strm_flags[2] = 3'b100; strm_en[2] = 3'b100; strm_ie[4] = 1;
    repeat (3) @(negedge clk);
    chk("R6 global bit set", int_status[9], 1);
    chk("R6 line low", {irq, irq_rise}, 0);
    glb_en = 0; strm_ie = '1; ctrl_en = 1;
    repeat (3) @(negedge clk);
    chk("R6 global enable off", {irq, irq_rise}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_stream();
    t_ctrl();
    t_line();
    t_gis_only();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule